// File: doc/BRIEF.md
# Gated Interval Measurement Counter

This block measures how long an active-low gate input is held low, counting in ticks of a fixed number of clock cycles. A one-cycle arm pulse clears the result and makes the block wait for the gate to go low. The gate is brought into the clock domain by a synchroniser. From the falling edge onward a prescaler produces one tick every `TICK_DIV` clocks, and each tick advances a counter built from cascaded byte registers. The rising edge of the gate ends the measurement and raises a done flag. If the counter runs past its top value before the gate returns high, the block stops and raises a separate error flag.

The result is read one byte at a time through a small read port. Each address below `NUM_BYTES` returns one count byte, least significant first, and the address just above them returns a status byte. With the default parameters the count is 24 bits wide in three bytes of weight 1, 256 and 65536, and one tick is 16 clocks. The result and the flags hold their values until the next arm pulse.

Top module: `gated_interval_timer`

## Requirements
- R1: After reset, done_o and err_o are 0 and every count byte and the status byte read as 0.
- R2: An arm pulse clears the count and both flags on the next clock edge and puts the block in its waiting state, and it does so in every state, including while counting.
- R3: Counting starts only on a high-to-low change of the gate seen after the arm pulse. A gate that is already low when arm arrives starts nothing until it has gone high and then low again.
- R4: While counting, the count goes up by exactly one for every TICK_DIV clocks. The prescaler starts from zero at the start of counting, so a gate held low for L clocks yields floor((L-1)/TICK_DIV) ticks.
- R5: A low-to-high change of the gate during counting ends the measurement with done_o = 1. The count and done_o then stay unchanged, whatever the gate does, until the next arm pulse.
- R6: The count is held as NUM_BYTES bytes. Address i (i < NUM_BYTES) reads byte i, where address 0 is the least significant byte, and each byte carries into the next, so byte i has weight 2^(BYTE_W*i).
- R7: When a tick arrives while all count bytes are at their maximum, the count wraps to zero and the block stops with err_o = 1 and done_o = 0. Later gate changes leave both untouched until the next arm pulse.
- R8: Address NUM_BYTES reads the status byte, with bit 0 = done and bit 1 = err and all other bits 0. Done and err are never 1 at the same time.
- R9: The gate passes through a two-stage synchroniser and an edge detector, so a state change caused by a gate edge takes effect at the third rising clock edge after the gate changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle pulse that clears the result and starts a new measurement |
| gate_n_i | input | 1 | Asynchronous active-low gate whose low time is measured |
| rd_addr_i | input | $clog2(NUM_BYTES+1) | Read address: count bytes, then the status byte |
| rd_data_o | output | BYTE_W | Read data for rd_addr_i (combinational) |
| done_o | output | 1 | Measurement ended normally |
| err_o | output | 1 | Measurement ended because the count overflowed |

## Verification
A wrong internal state shows up in two ways. Either the read bytes drift from the expected tick count, or the done and error flags appear in the wrong cycle, and both are visible within one clock. A prescaler that is off by one, or that is not cleared at the start of counting, shifts the count by one tick at a byte boundary. A broken carry shows up as a wrong upper byte once the low byte wraps. Mistakes in the edge detector or in the handling of arm show up as a count that starts while the gate is still low, or a result that changes after done, and the per-cycle comparison against the reference model reports it in the cycle it happens.

// File: rtl/gitm_pkg.sv
package gitm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_COUNT = 3'd2,
      ST_DONE  = 3'd3,
      ST_ERR   = 3'd4
   } gitm_state_e;
endpackage

// File: rtl/gitm_sync.sv
module gitm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_n,
   output logic fall,
   output logic rise
);
   // pipe[0..STAGES-1] form the synchroniser; pipe[STAGES] is the previous value
   logic [STAGES:0] pipe;

   generate
      for (genvar g = 0; g <= STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[0] <= 1'b1;
               else        pipe[0] <= d_n;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[g] <= 1'b1;
               else        pipe[g] <= pipe[g-1];
         end
      end
   endgenerate

   assign fall = pipe[STAGES] & ~pipe[STAGES-1];
   assign rise = ~pipe[STAGES] & pipe[STAGES-1];
endmodule

// File: rtl/gitm_prescaler.sv
module gitm_prescaler #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_div1
         assign tick = en;
      end else begin : g_divn
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         assign tick = en && (pre_q == LAST);

         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)   pre_q <= '0;
            else if (clr) pre_q <= '0;
            else if (en)  pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/gitm_cascade.sv
module gitm_cascade #(
   parameter int BW = 8,
   parameter int NB = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [NB*BW-1:0] value,
   output logic             wrap
);
   logic [NB:0] carry;
   assign carry[0] = inc;

   generate
      for (genvar g = 0; g < NB; g++) begin : g_byte
         logic [BW-1:0] b_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)        b_q <= '0;
            else if (clr)      b_q <= '0;
            else if (carry[g]) b_q <= b_q + 1'b1;
         assign carry[g+1]         = carry[g] & (&b_q);
         assign value[g*BW +: BW]  = b_q;
      end
   endgenerate

   assign wrap = carry[NB];
endmodule

// File: rtl/gated_interval_timer.sv
module gated_interval_timer #(
   parameter int BYTE_W      = 8,
   parameter int NUM_BYTES   = 3,
   parameter int TICK_DIV    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CW = BYTE_W * NUM_BYTES,
   localparam int AW = $clog2(NUM_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              gate_n_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic              done_o,
   output logic              err_o
);
   import gitm_pkg::*;

   generate
      if (BYTE_W < 2) begin : g_bad_bw
         $error("BYTE_W must be at least 2 to hold the status bits");
      end
      if (NUM_BYTES < 1) begin : g_bad_nb
         $error("NUM_BYTES must be at least 1");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   gitm_state_e   st_q;
   logic          fall_w, rise_w, tick_w, wrap_w;
   logic          counting;
   logic          inc_w;
   logic [CW-1:0] count_q;

   assign counting = (st_q == ST_COUNT);
   assign inc_w    = tick_w && !arm_i;

   gitm_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_n   (gate_n_i),
      .fall  (fall_w),
      .rise  (rise_w)
   );

   gitm_prescaler #(.DIV(TICK_DIV)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (arm_i || !counting),
      .en    (counting && !rise_w),
      .tick  (tick_w)
   );

   gitm_cascade #(.BW(BYTE_W), .NB(NUM_BYTES)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (arm_i),
      .inc   (inc_w),
      .value (count_q),
      .wrap  (wrap_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else if (arm_i) begin
         st_q <= ST_WAIT;
      end else begin
         unique case (st_q)
            ST_WAIT:  if (fall_w) st_q <= ST_COUNT;
            ST_COUNT: begin
               if (rise_w)                st_q <= ST_DONE;
               else if (tick_w && wrap_w) st_q <= ST_ERR;
            end
            default:  st_q <= st_q;
         endcase
      end
   end

   assign done_o = (st_q == ST_DONE);
   assign err_o  = (st_q == ST_ERR);

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NUM_BYTES; i++)
         if (rd_addr_i == AW'(i)) rd_data_o = count_q[i*BYTE_W +: BYTE_W];
      if (rd_addr_i == AW'(NUM_BYTES))
         rd_data_o = {{(BYTE_W-2){1'b0}}, err_o, done_o};
   end
endmodule

// File: rtl/gitm_checker.sv
module gitm_checker #(
   parameter int CW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm_i,
   input logic          done_o,
   input logic          err_o,
   input logic          counting,
   input logic [CW-1:0] count
);
   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (count == '0) && !done_o && !err_o);

   a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !arm_i) |=> done_o && $stable(count));

   a_r7_err_wraps_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (count == '0) && !done_o);

   a_r7_err_held: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !arm_i) |=> err_o && (count == '0));

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(arm_i) && (count != $past(count))) |->
         ($past(counting) && (count == CW'($past(count) + 1'b1))));
endmodule

bind gated_interval_timer gitm_checker #(.CW(CW)) i_gitm_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .arm_i    (arm_i),
   .done_o   (done_o),
   .err_o    (err_o),
   .counting (counting),
   .count    (count_q)
);

// File: tb/test_gated_interval_timer.sv
module test_gated_interval_timer;
   localparam int BW   = 4;
   localparam int NB   = 3;
   localparam int DIV  = 4;
   localparam int CW   = BW * NB;
   localparam int AW   = 2;
   localparam int MAXC = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0;
   logic          gate_n = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic [BW-1:0] rd_data;
   logic          done, err;

   always #4 clk = ~clk;   // 125 MHz

   gated_interval_timer #(.BYTE_W(BW), .NUM_BYTES(NB), .TICK_DIV(DIV), .SYNC_STAGES(2))
      i_gated_interval_timer (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .gate_n_i(gate_n),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .done_o(done), .err_o(err));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model: 0 idle, 1 wait, 2 count, 3 done, 4 err
   int m_s1 = 1, m_s2 = 1, m_s3 = 1;
   int m_st = 0, m_cnt = 0, m_pre = 0;
   bit m_fall, m_rise;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_s3 = 1; m_st = 0; m_cnt = 0; m_pre = 0;
      end else begin
         m_fall = (m_s3 == 1) && (m_s2 == 0);
         m_rise = (m_s3 == 0) && (m_s2 == 1);
         if (arm) begin
            m_st = 1; m_cnt = 0; m_pre = 0;
         end else if (m_st == 1) begin
            m_pre = 0;
            if (m_fall) m_st = 2;
         end else if (m_st == 2) begin
            if (m_rise) m_st = 3;
            else if (m_pre == DIV - 1) begin
               m_pre = 0;
               m_cnt++;
               if (m_cnt == MAXC) begin m_cnt = 0; m_st = 4; end
            end else m_pre++;
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(gate_n);
      end
   end

   function automatic int model_reg(int a);
      if (a < NB)  return (m_cnt >> (BW * a)) & ((1 << BW) - 1);
      if (a == NB) return ((m_st == 4) ? 2 : 0) + ((m_st == 3) ? 1 : 0);
      return 0;
   endfunction

   // Per-cycle comparison, away from the clock edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         chk("R5 done flag vs model", int'(done), int'(m_st == 3));
         chk("R7 err flag vs model", int'(err), int'(m_st == 4));
         chk("R9 read data vs model", int'(rd_data), model_reg(int'(rd_addr)));
      end
   end

   task automatic read_reg(int a, output int v);
      @(negedge clk) rd_addr = AW'(a);
      @(posedge clk); #2;
      v = int'(rd_data);
   endtask

   task automatic do_arm();
      @(negedge clk) arm = 1'b1;
      @(negedge clk) arm = 1'b0;
   endtask

   task automatic pulse_low(int len);
      @(negedge clk) gate_n = 1'b0;
      repeat (len) @(negedge clk);
      gate_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic check_count(string req, int exp);
      int v;
      for (int i = 0; i < NB; i++) begin
         read_reg(i, v);
         chk(req, v, (exp >> (BW * i)) & ((1 << BW) - 1));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 done after reset", int'(done), 0);
      chk("R1 err after reset", int'(err), 0);
      check_count("R1 count after reset", 0);
      read_reg(NB, v); chk("R1 status after reset", v, 0);

      // R4 basic interval, then R5 hold and R8 status
      do_arm();
      pulse_low(41);
      check_count("R4 count for 41 low clocks", (41 - 1) / DIV);
      read_reg(NB, v); chk("R8 status shows done", v, 1);
      pulse_low(20);
      check_count("R5 count held after done", 10);
      chk("R5 done still set", int'(done), 1);

      // R4 boundaries: first tick exactly DIV clocks in
      do_arm(); pulse_low(DIV);
      check_count("R4 low for DIV clocks", 0);
      do_arm(); pulse_low(DIV + 1);
      check_count("R4 low for DIV+1 clocks", 1);
      do_arm(); pulse_low(1);
      check_count("R4 single-clock low", 0);
      chk("R4 single-clock low gives done", int'(done), 1);

      // R3 gate already low at arm
      @(negedge clk) gate_n = 1'b0;
      repeat (6) @(negedge clk);
      do_arm();
      repeat (12) @(negedge clk);
      chk("R3 no count while already low", int'(done), 0);
      check_count("R3 count stays zero", 0);
      gate_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R3 rise in wait does not end", int'(done), 0);
      pulse_low(9);
      check_count("R3 count after fresh fall", 2);

      // R2 arm during counting restarts
      do_arm();
      @(negedge clk) gate_n = 1'b0;
      repeat (30) @(negedge clk);
      do_arm();
      @(negedge clk);
      check_count("R2 count cleared by arm while counting", 0);
      chk("R2 done cleared", int'(done), 0);
      repeat (10) @(negedge clk);
      check_count("R2 no restart without new fall", 0);
      gate_n = 1'b1;
      repeat (6) @(negedge clk);
      pulse_low(13);
      check_count("R2 fresh measurement after restart", 3);

      // R6 carries across bytes: 300 ticks
      do_arm(); pulse_low(DIV * 300 + 1);
      check_count("R6 multi-byte count 300", 300);

      // R7 overflow
      do_arm(); pulse_low(DIV * MAXC + 16);
      chk("R7 err set", int'(err), 1);
      chk("R7 done clear", int'(done), 0);
      check_count("R7 count wrapped to zero", 0);
      read_reg(NB, v); chk("R8 status shows err", v, 2);
      pulse_low(10);
      chk("R7 err held after gate activity", int'(err), 1);
      do_arm();
      @(negedge clk);
      chk("R2 arm clears err", int'(err), 0);

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule